// File: doc/BRIEF.md
# Micro-operation cracking sequencer

This block sits at the issue point of a small in-order core whose register file can accept only one write per cycle. It takes one decoded instruction at a time over a valid/ready handshake and expands it into an ordered list of micro-operations. Each micro-operation writes at most one register and is presented to the execute stage with its operation code, its target register, a write-enable bit, and first/last markers. The instruction port stays closed until the whole list has left.

Instructions that write two registers, and word-group loads and stores, are the ones that get expanded: a word group becomes one micro-operation per word plus an optional base-register update. Post-increment loads, register pair moves, divides, multiply-accumulates and register-offset stores each become two. Slow multiplies and divides also hold the execute stage busy for a fixed number of cycles. The block exposes that occupancy on a busy output.

Top module: `uop_crack_seq`

## Requirements
- R1: While reset is high and after it falls, `in_ready`=1, `uop_valid`=0 and `ex_busy`=0.
- R2: `in_ready` is high only when no sequence is in progress. It is low from the cycle after an instruction is taken until the cycle after the last micro-op is accepted and any busy period has ended.
- R3: Word-group load (`in_kind`=5) and store (`in_kind`=6) with count N give N micro-ops in order. Micro-op i has target `in_rd`+i, wrapping at the register count. Loads use op 1 (LOAD) with `uop_wen`=1. Stores use op 2 (STORE, carries data) with `uop_wen`=0.
- R4: When `in_wb`=1, a word group gets one more micro-op at the end: op 4 (BASE), target `in_rs`, `uop_wen`=1.
- R5: A post-increment load (`in_kind`=2) gives op 1 to `in_rd`, then op 4 to `in_rs`. Both write.
- R6: A pair move (`in_kind`=7) gives op 5 twice. The first targets `in_rd` with bit 0 cleared; the second targets `in_rd` with bit 0 set.
- R7: A divide (`in_kind`=8) gives op 6 (quotient) to `in_rd`. Then `ex_busy` is high for exactly 36 cycles with no micro-op. Then op 7 (remainder) goes to `in_rs`.
- R8: A multiply-accumulate (`in_kind`=10) gives op 8 (multiply) to `in_rd` with `uop_wen`=0, then op 9 (accumulate) to `in_rd` with `uop_wen`=1. If `mul_slow` was 1 when the instruction was taken, 15 busy cycles separate the two.
- R9: A multiply (`in_kind`=9) gives one op 8 to `in_rd` with `uop_wen`=1. With `mul_slow`=1 it is followed by 15 busy cycles, so execute is occupied for 16 cycles in total. With `mul_slow`=0 there are no busy cycles.
- R10: A register-offset store (`in_kind`=4) gives op 3 (address only, no data), then op 2 (data). Both target `in_rd` with `uop_wen`=0.
- R11: `in_kind` 11..15, or a word-group count outside 1..8 and 12, raises `illegal` in the cycle the instruction is offered. The instruction is consumed and nothing is issued.
- R12: While `uop_valid`=1 and `uop_ready`=0, the next cycle shows the same micro-op. No micro-op is dropped or repeated.
- R13: ALU (`in_kind`=0, op 0), load (1, op 1) and immediate-offset store (3, op 2, `uop_wen`=0) each give one micro-op to `in_rd`, marked both first and last.
- R14: A synchronous reset in the middle of a sequence returns the block to idle on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| in_kind | input | 4 | Instruction kind code |
| in_rd | input | REG_AW | Primary/first target register |
| in_rs | input | REG_AW | Secondary target (base or remainder) |
| in_count | input | CNT_W | Word count for word-group access |
| in_wb | input | 1 | Word group updates its base register |
| mul_slow | input | 1 | Iterative multiplier mode |
| illegal | output | 1 | Offered instruction is unsupported |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Execute accepts micro-op |
| uop_op | output | 4 | Micro-op operation code |
| uop_dst | output | REG_AW | Micro-op target register |
| uop_wen | output | 1 | Micro-op writes its target |
| uop_first | output | 1 | First micro-op of instruction |
| uop_last | output | 1 | Last micro-op of instruction |
| ex_busy | output | 1 | Execute held by long operation |

## Verification
The hardest situation to reach is back-pressure that lands on a sequence boundary. Examples are a stall on the final micro-op just before the port reopens, or a stall on the micro-op that starts a busy period. Either could make the sequence repeat or skip a word. The stimulus drops `uop_ready` at random on about a quarter of the cycles across a long random mix of all instruction kinds. It adds directed twelve-word groups that wrap the register index, and a reset that lands in the middle of a group.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam logic [3:0] K_ALU        = 4'd0;
   localparam logic [3:0] K_LOAD       = 4'd1;
   localparam logic [3:0] K_LOAD_POST  = 4'd2;
   localparam logic [3:0] K_STORE_IMM  = 4'd3;
   localparam logic [3:0] K_STORE_REG  = 4'd4;
   localparam logic [3:0] K_GRP_LOAD   = 4'd5;
   localparam logic [3:0] K_GRP_STORE  = 4'd6;
   localparam logic [3:0] K_MOVE_PAIR  = 4'd7;
   localparam logic [3:0] K_DIVIDE     = 4'd8;
   localparam logic [3:0] K_MULTIPLY   = 4'd9;
   localparam logic [3:0] K_MUL_ACC    = 4'd10;

   typedef enum logic [3:0] {
      OP_ALU    = 4'd0,
      OP_LD     = 4'd1,
      OP_ST     = 4'd2,
      OP_STADDR = 4'd3,
      OP_BASE   = 4'd4,
      OP_MOV    = 4'd5,
      OP_DIVQ   = 4'd6,
      OP_DIVR   = 4'd7,
      OP_MUL    = 4'd8,
      OP_ACC    = 4'd9
   } uop_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEQ  = 2'd1,
      ST_HOLD = 2'd2
   } seq_state_e;
endpackage

// File: rtl/useq_decode.sv
module useq_decode
   import useq_pkg::*;
#(
   parameter int CNT_W        = 4,
   parameter int RUN_MAX      = 8,
   parameter int RUN_LONG     = 12,
   parameter int MUL_SLOW_CYC = 16,
   parameter int DIV_CYC      = 36,
   parameter int IDX_W        = 4,
   parameter int HOLD_W       = 6
) (
   input  logic [3:0]        kind,
   input  logic [CNT_W-1:0]  count,
   input  logic              wb,
   input  logic              slow,
   output logic              legal,
   output logic [IDX_W-1:0]  n_uops,
   output logic [HOLD_W-1:0] hold_len
);
   logic long_hit;
   logic cnt_ok;
   logic grp;

   generate
      if (RUN_LONG > 0) begin : g_long
         assign long_hit = (count == CNT_W'(RUN_LONG));
      end else begin : g_nolong
         assign long_hit = 1'b0;
      end
   endgenerate

   assign cnt_ok = ((count != '0) && (count <= CNT_W'(RUN_MAX))) || long_hit;
   assign grp    = (kind == K_GRP_LOAD) || (kind == K_GRP_STORE);

   always_comb begin
      legal    = (kind <= K_MUL_ACC) && (!grp || cnt_ok);
      hold_len = '0;
      n_uops   = IDX_W'(1);
      case (kind)
         K_LOAD_POST, K_STORE_REG, K_MOVE_PAIR: n_uops = IDX_W'(2);
         K_GRP_LOAD, K_GRP_STORE: n_uops = IDX_W'(count) + IDX_W'(wb);
         K_DIVIDE: begin
            n_uops   = IDX_W'(2);
            hold_len = HOLD_W'(DIV_CYC);
         end
         K_MULTIPLY: begin
            if (slow) hold_len = HOLD_W'(MUL_SLOW_CYC - 1);
         end
         K_MUL_ACC: begin
            n_uops = IDX_W'(2);
            if (slow) hold_len = HOLD_W'(MUL_SLOW_CYC - 1);
         end
         default: n_uops = IDX_W'(1);
      endcase
   end
endmodule

// File: rtl/useq_gen.sv
module useq_gen
   import useq_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter int CNT_W  = 4,
   parameter int IDX_W  = 4
) (
   input  logic [3:0]        kind,
   input  logic [REG_AW-1:0] rd,
   input  logic [REG_AW-1:0] rs,
   input  logic [CNT_W-1:0]  count,
   input  logic [IDX_W-1:0]  idx,
   input  logic [IDX_W-1:0]  n_uops,
   output uop_e              op,
   output logic [REG_AW-1:0] dst,
   output logic              wen,
   output logic              first,
   output logic              last
);
   logic at0;
   logic in_words;

   assign at0      = (idx == '0);
   assign in_words = int'(idx) < int'(count);
   assign first    = at0;
   assign last     = (idx == n_uops - IDX_W'(1));

   always_comb begin
      op  = OP_ALU;
      dst = rd;
      wen = 1'b1;
      case (kind)
         K_ALU:       op = OP_ALU;
         K_LOAD:      op = OP_LD;
         K_LOAD_POST: begin
            op  = at0 ? OP_LD : OP_BASE;
            dst = at0 ? rd : rs;
         end
         K_STORE_IMM: begin
            op  = OP_ST;
            wen = 1'b0;
         end
         K_STORE_REG: begin
            op  = at0 ? OP_STADDR : OP_ST;
            wen = 1'b0;
         end
         K_GRP_LOAD, K_GRP_STORE: begin
            if (in_words) begin
               op  = (kind == K_GRP_LOAD) ? OP_LD : OP_ST;
               dst = rd + REG_AW'(idx);
               wen = (kind == K_GRP_LOAD);
            end else begin
               op  = OP_BASE;
               dst = rs;
            end
         end
         K_MOVE_PAIR: begin
            op  = OP_MOV;
            dst = {rd[REG_AW-1:1], idx[0]};
         end
         K_DIVIDE: begin
            op  = at0 ? OP_DIVQ : OP_DIVR;
            dst = at0 ? rd : rs;
         end
         K_MULTIPLY:  op = OP_MUL;
         K_MUL_ACC: begin
            op  = at0 ? OP_MUL : OP_ACC;
            wen = !at0;
         end
         default: wen = 1'b0;
      endcase
   end
endmodule

// File: rtl/useq_hold.sv
module useq_hold #(
   parameter int HOLD_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [HOLD_W-1:0] len,
   output logic              busy,
   output logic              expire
);
   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (load)        cnt_q <= len;
      else if (cnt_q != '0) cnt_q <= cnt_q - HOLD_W'(1);
   end

   assign busy   = (cnt_q != '0);
   assign expire = (cnt_q == HOLD_W'(1));

   // R7
   hold_step_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !load) |=> (cnt_q == $past(cnt_q) - HOLD_W'(1)));
endmodule

// File: rtl/uop_crack_seq.sv
module uop_crack_seq
   import useq_pkg::*;
#(
   parameter int REG_AW       = 5,
   parameter int CNT_W        = 4,
   parameter int RUN_MAX      = 8,
   parameter int RUN_LONG     = 12,
   parameter int MUL_SLOW_CYC = 16,
   parameter int DIV_CYC      = 36
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [3:0]        in_kind,
   input  logic [REG_AW-1:0] in_rd,
   input  logic [REG_AW-1:0] in_rs,
   input  logic [CNT_W-1:0]  in_count,
   input  logic              in_wb,
   input  logic              mul_slow,
   output logic              illegal,
   output logic              uop_valid,
   input  logic              uop_ready,
   output logic [3:0]        uop_op,
   output logic [REG_AW-1:0] uop_dst,
   output logic              uop_wen,
   output logic              uop_first,
   output logic              uop_last,
   output logic              ex_busy
);
   localparam int RUN_TOP = (RUN_LONG > RUN_MAX) ? RUN_LONG : RUN_MAX;
   localparam int MAXU    = RUN_TOP + 1;
   localparam int IDX_W   = $clog2(MAXU + 1);
   localparam int HMAX    = (DIV_CYC > MUL_SLOW_CYC) ? DIV_CYC : MUL_SLOW_CYC;
   localparam int HOLD_W  = $clog2(HMAX + 1);

   generate
      if (REG_AW < 2) begin : g_bad_reg
         $error("REG_AW must be at least 2");
      end
      if (RUN_TOP >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for word counts");
      end
      if (MUL_SLOW_CYC < 2 || DIV_CYC < 1) begin : g_bad_hold
         $error("hold lengths out of range");
      end
   endgenerate

   seq_state_e         state_q;
   logic [3:0]         kind_q;
   logic [REG_AW-1:0]  rd_q, rs_q;
   logic [CNT_W-1:0]   count_q;
   logic [IDX_W-1:0]   idx_q, n_q;
   logic [HOLD_W-1:0]  hold_q;

   logic               legal_in;
   logic [IDX_W-1:0]   n_in;
   logic [HOLD_W-1:0]  hold_in;
   uop_e               g_op;
   logic               fire, accept, t_load, t_busy, t_expire;

   useq_decode #(
      .CNT_W(CNT_W), .RUN_MAX(RUN_MAX), .RUN_LONG(RUN_LONG),
      .MUL_SLOW_CYC(MUL_SLOW_CYC), .DIV_CYC(DIV_CYC),
      .IDX_W(IDX_W), .HOLD_W(HOLD_W)
   ) u_dec (
      .kind(in_kind), .count(in_count), .wb(in_wb), .slow(mul_slow),
      .legal(legal_in), .n_uops(n_in), .hold_len(hold_in)
   );

   useq_gen #(.REG_AW(REG_AW), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_gen (
      .kind(kind_q), .rd(rd_q), .rs(rs_q), .count(count_q),
      .idx(idx_q), .n_uops(n_q),
      .op(g_op), .dst(uop_dst), .wen(uop_wen),
      .first(uop_first), .last(uop_last)
   );

   useq_hold #(.HOLD_W(HOLD_W)) u_hold (
      .clk(clk), .rst(rst), .load(t_load), .len(hold_q),
      .busy(t_busy), .expire(t_expire)
   );

   assign in_ready  = (state_q == ST_IDLE);
   assign illegal   = in_valid && in_ready && !legal_in;
   assign accept    = in_valid && in_ready && legal_in;
   assign uop_valid = (state_q == ST_SEQ);
   assign uop_op    = g_op;
   assign ex_busy   = (state_q == ST_HOLD);
   assign fire      = uop_valid && uop_ready;
   assign t_load    = fire && (idx_q == '0) && (hold_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         kind_q  <= '0;
         rd_q    <= '0;
         rs_q    <= '0;
         count_q <= '0;
         n_q     <= '0;
         hold_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  kind_q  <= in_kind;
                  rd_q    <= in_rd;
                  rs_q    <= in_rs;
                  count_q <= in_count;
                  n_q     <= n_in;
                  hold_q  <= hold_in;
                  idx_q   <= '0;
                  state_q <= ST_SEQ;
               end
            end
            ST_SEQ: begin
               if (fire) begin
                  idx_q <= idx_q + IDX_W'(1);
                  if (t_load)        state_q <= ST_HOLD;
                  else if (uop_last) state_q <= ST_IDLE;
               end
            end
            ST_HOLD: begin
               if (t_expire) state_q <= (idx_q == n_q) ? ST_IDLE : ST_SEQ;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) && $stable(uop_dst) && $stable(uop_wen)));
   // R2
   port_closed_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid || ex_busy) |-> !in_ready);
   // R2
   start_seq_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> (uop_valid && uop_first));
   // R11
   illegal_drop_chk: assert property (@(posedge clk) disable iff (rst)
      illegal |=> (in_ready && !uop_valid));
   // R7
   busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
      ex_busy |-> (!uop_valid && t_busy));
   // R6
   pair_order_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid && uop_op == 4'(OP_MOV)) |-> (uop_dst[0] == uop_last));
endmodule

// File: tb/sim_uop_crack_seq.sv
module sim_uop_crack_seq;
   logic       clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst, in_valid, in_ready, in_wb, mul_slow, illegal;
   logic [3:0] in_kind, in_count, uop_op;
   logic [4:0] in_rd, in_rs, uop_dst;
   logic       uop_valid, uop_ready, uop_wen, uop_first, uop_last, ex_busy;

   uop_crack_seq u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_rd(in_rd), .in_rs(in_rs), .in_count(in_count),
      .in_wb(in_wb), .mul_slow(mul_slow), .illegal(illegal),
      .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
      .uop_dst(uop_dst), .uop_wen(uop_wen), .uop_first(uop_first),
      .uop_last(uop_last), .ex_busy(ex_busy)
   );

   int checks = 0, fails = 0;
   bit finished = 0;
   logic [3:0] e_op [16];
   logic [4:0] e_dst[16];
   logic       e_wen[16];
   int e_n, e_hold;
   bit e_ill;

   task automatic chk(bit ok, string rq, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic push(int op, logic [4:0] dst, bit wen);
      e_op[e_n] = 4'(op); e_dst[e_n] = dst; e_wen[e_n] = wen; e_n++;
   endtask

   function automatic bit cnt_legal(int c);
      return (c >= 1 && c <= 8) || c == 12;
   endfunction

   task automatic build(int k, logic [4:0] rd, logic [4:0] rs, int c, bit wb, bit slow);
      e_n = 0; e_hold = 0; e_ill = 0;
      case (k)
         0: push(0, rd, 1);
         1: push(1, rd, 1);
         2: begin push(1, rd, 1); push(4, rs, 1); end
         3: push(2, rd, 0);
         4: begin push(3, rd, 0); push(2, rd, 0); end
         5, 6: begin
            if (!cnt_legal(c)) e_ill = 1;
            else begin
               for (int i = 0; i < c; i++) push(k == 5 ? 1 : 2, 5'(rd + 5'(i)), k == 5);
               if (wb) push(4, rs, 1);
            end
         end
         7: begin push(5, {rd[4:1], 1'b0}, 1); push(5, {rd[4:1], 1'b1}, 1); end
         8: begin push(6, rd, 1); push(7, rs, 1); e_hold = 36; end
         9: begin push(8, rd, 1); e_hold = slow ? 15 : 0; end
         10: begin push(8, rd, 0); push(9, rd, 1); e_hold = slow ? 15 : 0; end
         default: e_ill = 1;
      endcase
   endtask

   function automatic string tag(int k, bit wb, bit slow);
      case (k)
         0, 1, 3: return "R13";
         2: return "R5";
         4: return "R10";
         5, 6: return wb ? "R4" : "R3";
         7: return "R6";
         8: return "R7";
         9: return slow ? "R9" : "R13";
         10: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic run(int k, logic [4:0] rd, logic [4:0] rs, int c, bit wb, bit slow);
      string rq;
      int kk, busy, guard;
      bit stalled, done;
      logic [3:0] s_op;
      logic [4:0] s_dst;
      build(k, rd, rs, c, wb, slow);
      rq = tag(k, wb, slow);
      @(negedge clk);
      in_valid = 1; in_kind = 4'(k); in_rd = rd; in_rs = rs;
      in_count = 4'(c); in_wb = wb; mul_slow = slow; uop_ready = 0;
      #1;
      chk(in_ready == 1, "R2", "ready at offer", in_ready, 1);
      chk(illegal == e_ill, "R11", "illegal flag", illegal, e_ill);
      @(negedge clk);
      in_valid = 0; mul_slow = ~slow;
      if (e_ill) begin
         #1;
         chk(!uop_valid && in_ready, "R11", "dropped instr valid", uop_valid, 0);
         return;
      end
      kk = 0; busy = 0; guard = 0; stalled = 0; done = 0;
      s_op = '0; s_dst = '0;
      while (!done) begin
         uop_ready = ($urandom % 4) != 0;
         #1;
         if (stalled) begin
            chk(uop_valid && uop_op == s_op && uop_dst == s_dst, "R12", "stalled uop held", int'(uop_op), int'(s_op));
            stalled = 0;
         end
         if (in_ready) begin
            done = 1;
         end else begin
            if (ex_busy && kk != 1) chk(0, rq, "busy position", kk, 1);
            if (ex_busy) busy++;
            if (uop_valid) begin
               if (uop_ready) begin
                  if (kk >= e_n) chk(0, rq, "extra uop", kk, e_n);
                  else chk(uop_op == e_op[kk] && uop_dst == e_dst[kk] && uop_wen == e_wen[kk]
                           && uop_first == (kk == 0) && uop_last == (kk == e_n - 1),
                           rq, "uop fields {op,dst,wen,f,l}",
                           int'({uop_op, uop_dst, uop_wen, uop_first, uop_last}),
                           int'({e_op[kk], e_dst[kk], e_wen[kk], kk == 0, kk == e_n - 1}));
                  kk++;
               end else begin
                  stalled = 1; s_op = uop_op; s_dst = uop_dst;
               end
            end
            guard++;
            if (guard > 300) begin
               chk(0, rq, "sequence hung", guard, 0);
               done = 1;
            end
            if (!done) @(negedge clk);
         end
      end
      chk(kk == e_n, (kk < e_n) ? "R2" : rq, "uop count before reopen", kk, e_n);
      chk(busy == e_hold, rq, "busy cycles", busy, e_hold);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst = 1; in_valid = 0; in_kind = 0; in_rd = 0; in_rs = 0;
      in_count = 0; in_wb = 0; mul_slow = 0; uop_ready = 0;
      repeat (2) @(negedge clk);
      #1;
      chk(in_ready && !uop_valid && !ex_busy, "R1", "idle during reset", int'({in_ready, uop_valid, ex_busy}), 4);
      rst = 0;
      @(negedge clk); #1;
      chk(in_ready && !uop_valid && !ex_busy, "R1", "idle after reset", int'({in_ready, uop_valid, ex_busy}), 4);

      run(0, 5'd3, 5'd0, 0, 0, 0);
      run(1, 5'd9, 5'd0, 0, 0, 0);
      run(3, 5'd17, 5'd0, 0, 0, 0);
      run(2, 5'd4, 5'd20, 0, 0, 0);
      run(4, 5'd6, 5'd1, 0, 0, 0);
      run(5, 5'd2, 5'd30, 1, 0, 0);
      run(5, 5'd24, 5'd30, 8, 1, 0);
      run(6, 5'd25, 5'd1, 12, 1, 0);
      run(5, 5'd31, 5'd2, 12, 0, 0);
      run(7, 5'd7, 5'd0, 0, 0, 0);
      run(7, 5'd10, 5'd0, 0, 0, 0);
      run(8, 5'd11, 5'd12, 0, 0, 0);
      run(9, 5'd13, 5'd0, 0, 0, 1);
      run(9, 5'd13, 5'd0, 0, 0, 0);
      run(10, 5'd14, 5'd0, 0, 0, 1);
      run(10, 5'd15, 5'd0, 0, 0, 0);
      run(5, 5'd1, 5'd2, 0, 1, 0);
      run(6, 5'd1, 5'd2, 9, 0, 0);
      run(5, 5'd1, 5'd2, 13, 0, 0);
      run(13, 5'd1, 5'd2, 1, 0, 0);

      for (int n = 0; n < 80; n++)
         run(int'($urandom % 13), 5'($urandom), 5'($urandom), int'($urandom % 14),
             1'($urandom), 1'($urandom));

      // R14: reset in the middle of a word group
      @(negedge clk);
      in_valid = 1; in_kind = 4'd5; in_count = 4'd8; in_rd = 5'd0; in_wb = 1; uop_ready = 1;
      @(negedge clk);
      in_valid = 0;
      repeat (2) @(negedge clk);
      #1;
      chk(uop_valid && !in_ready, "R14", "mid-sequence before reset", uop_valid, 1);
      rst = 1;
      @(negedge clk);
      rst = 0; #1;
      chk(in_ready && !uop_valid, "R14", "idle after abort", int'({in_ready, uop_valid}), 2);
      run(0, 5'd21, 5'd0, 0, 0, 0);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule